// File: doc/BRIEF.md
# Configuration Bitstream Header Parser

This block sits in the path that loads a configuration image into a programmable device. It takes the image as a byte stream and drops everything in front of the configuration payload. The dropped part is the descriptive header, made of a fixed prelude followed by length-prefixed text records, together with any filler before the sync preamble. Only the payload goes out on a ready/valid byte output. When the block finds the payload, it reports the byte offset where the payload begins and how many bytes it holds. When no sync preamble exists, it raises a not-found flag and forwards nothing.

A parameter selects one of two image flavours. The uncompressed flavour first walks the header records from a fixed offset. It then looks for a run of four 0xFF bytes, and that run is the first part of the payload. The compressed flavour ignores the records and scans from the very first byte for a 0xFF byte followed by a byte whose upper nibble is 3. The payload starts right after that two-byte marker, and the marker is not forwarded.

The total file length is given as an input. Files may follow one another with no gap. The byte after the last byte of one file is offset 0 of the next file.

Top module: `bitstream_hdr_parser`

## Requirements
- R1: After reset the input is ready, no output byte is valid, and both the found flag and the not-found flag are low.
- R2: In uncompressed mode, bytes 0 to 14 are skipped. The byte at offset 15 is a record length L. Each following record length sits L+3 bytes after the previous one. After four records, the preamble search starts at the byte L+3 past the fourth length byte. Any 0xFF bytes before that point, including those inside record text, never count toward the preamble.
- R3: In uncompressed mode the preamble is the first run of four consecutive 0xFF bytes in the search region. The payload start is the offset of the first of those four bytes. The output carries the four 0xFF bytes and then every later byte of the file.
- R4: Header bytes, record text and bytes before the payload start are never forwarded. A file produces exactly file-length minus payload-start output bytes when it has a payload, and none when it does not.
- R5: In compressed mode the search covers the whole file from offset 0. It matches a 0xFF byte at offset p followed at p+1 by a byte whose bits 7:4 equal 4'h3, with p at most file length minus 2. The payload start is p+2, and the two marker bytes are not forwarded.
- R6: When a payload is found, the found flag rises. The start offset and the length (file length minus start offset) are presented and held until the first byte of the next file is accepted. A length of zero is valid.
- R7: When the file ends without a match, including a file that ends inside the header, the not-found flag rises and is held like the found flag. The found flag stays low.
- R8: After the last byte of a file (per the file length input, held stable during the file), the next accepted byte is treated as offset 0 of a new file, with all search state cleared.
- R9: Output backpressure stalls the stream without loss or duplication. The output bytes equal the file bytes from the payload start onward, in order.
- R10: Overlapping candidates resolve to the earliest match. In uncompressed mode a run of five 0xFF starts at the first one, and a run of three 0xFF followed by another byte does not match. In compressed mode 0xFF 0xFF 0x3X matches at the second 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fileLen | input | LEN_W | Total byte count of the current file, stable while it streams |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inReady | output | 1 | Block accepts the input byte this cycle |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output payload byte |
| outReady | input | 1 | Downstream accepts the output byte |
| payloadFound | output | 1 | Payload located in the last file |
| notFound | output | 1 | Last file ended with no preamble |
| payloadStart | output | LEN_W | Byte offset of the payload start |
| payloadLen | output | LEN_W | Payload byte count |

## Verification
The hardest case to reach from the ports is a preamble that begins on the exact byte where the record walk ends, right behind record text that is itself all 0xFF. A second hard case is a four-byte run that ends on the last byte of the file, so the replay of the preamble runs after the input has already finished. The bench fills every record's text with 0xFF and sweeps the first record length, the filler gap (including zero), decoy three-byte runs and five-byte runs. It also builds files whose preamble forms the final four bytes. In compressed mode the marker is walked across every position of a short file, up to the two last bytes. Every file is compared against offsets the bench computes from the record layout, with random output backpressure on alternate files.

// File: rtl/bshp_pkg.sv
package bshp_pkg;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_SCAN,
    ST_EMIT,
    ST_PASS
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    logic take;      // input byte accepted this cycle
    logic clrFile;   // end of file: clear per-file state
    logic loadRec;   // current byte is a record length
    logic scanByte;  // current byte belongs to the search region
    logic markHit;   // preamble recognised
    logic markMiss;  // file ended without a preamble
    logic emitStep;  // one replayed preamble byte left
    logic emitting;  // output carries a replayed preamble byte
  } strobeT;

  // status from datapath to control
  typedef struct packed {
    logic atRec;
    logic scanNext;
    logic lastByte;
    logic hit;
    logic emitLast;
    logic tailEnd;
  } dpStatusT;

endpackage

// File: rtl/bshp_datapath.sv
module bshp_datapath
  import bshp_pkg::*;
#(
  parameter bit RAW_MODE  = 1'b1,
  parameter int LEN_W     = 16,
  parameter int HDR_START = 15,
  parameter int NUM_RECS  = 4,
  parameter int PRE_RUN   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [7:0]       inData,
  input  logic [LEN_W-1:0] fileLen,
  output dpStatusT         stat,
  output logic [7:0]       outData,
  output logic             payloadFound,
  output logic             notFound,
  output logic [LEN_W-1:0] payloadStart,
  output logic [LEN_W-1:0] payloadLen
);

  localparam int PTR_W = LEN_W + 2;
  localparam int CW    = LEN_W + 1;
  localparam int REC_W = $clog2(NUM_RECS + 1);
  localparam int RUN_W = $clog2(PRE_RUN + 1);

  logic [LEN_W-1:0] cnt;
  logic [PTR_W-1:0] nextPos;
  logic [REC_W-1:0] recCnt;
  logic [RUN_W-1:0] emitLeft;
  logic [LEN_W-1:0] startReg, lenReg;
  logic             foundReg, missReg, tailEndReg;
  logic             hitC;
  logic [LEN_W-1:0] startNext;

  // byte position bookkeeping and header record walk
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrFile) begin
      cnt     <= '0;
      nextPos <= PTR_W'(HDR_START);
      recCnt  <= '0;
    end else if (stb.take) begin
      cnt <= cnt + LEN_W'(1);
      if (stb.loadRec) begin
        nextPos <= PTR_W'(cnt) + PTR_W'(inData) + PTR_W'(3);
        recCnt  <= recCnt + REC_W'(1);
      end
    end
  end

  // mode-specific preamble recogniser
  generate
    if (RAW_MODE) begin : g_raw
      logic [RUN_W-1:0] runCnt;
      always_ff @(posedge clk) begin
        if (!rstN || stb.clrFile) begin
          runCnt <= '0;
        end else if (stb.scanByte) begin
          if (inData != 8'hFF)                       runCnt <= '0;
          else if (runCnt == RUN_W'(PRE_RUN - 1))    runCnt <= '0;
          else                                       runCnt <= runCnt + RUN_W'(1);
        end
      end
      assign hitC      = (inData == 8'hFF) && (runCnt == RUN_W'(PRE_RUN - 1));
      assign startNext = cnt - LEN_W'(PRE_RUN - 1);
    end else begin : g_cmp
      logic prevFF;
      always_ff @(posedge clk) begin
        if (!rstN || stb.clrFile) prevFF <= 1'b0;
        else if (stb.scanByte)    prevFF <= (inData == 8'hFF);
      end
      assign hitC      = prevFF && (inData[7:4] == 4'h3);
      assign startNext = cnt + LEN_W'(1);
    end
  endgenerate

  // preamble replay counter
  always_ff @(posedge clk) begin
    if (!rstN)             emitLeft <= '0;
    else if (stb.markHit)  emitLeft <= RUN_W'(PRE_RUN);
    else if (stb.emitStep) emitLeft <= emitLeft - RUN_W'(1);
  end

  // result registers, held until the next file begins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      foundReg   <= 1'b0;
      missReg    <= 1'b0;
      tailEndReg <= 1'b0;
      startReg   <= '0;
      lenReg     <= '0;
    end else begin
      if (stb.take && cnt == '0) begin
        foundReg <= 1'b0;
        missReg  <= 1'b0;
      end
      if (stb.markHit) begin
        foundReg   <= 1'b1;
        startReg   <= startNext;
        lenReg     <= fileLen - startNext;
        tailEndReg <= stat.lastByte;
      end
      if (stb.markMiss) missReg <= 1'b1;
    end
  end

  assign stat.atRec    = (recCnt < REC_W'(NUM_RECS)) && (PTR_W'(cnt) == nextPos);
  assign stat.scanNext = (recCnt == REC_W'(NUM_RECS)) && (PTR_W'(cnt) + PTR_W'(1) == nextPos);
  assign stat.lastByte = (CW'(cnt) + CW'(1)) == CW'(fileLen);
  assign stat.hit      = hitC;
  assign stat.emitLast = (emitLeft == RUN_W'(1));
  assign stat.tailEnd  = tailEndReg;

  assign outData      = stb.emitting ? 8'hFF : inData;
  assign payloadFound = foundReg;
  assign notFound     = missReg;
  assign payloadStart = startReg;
  assign payloadLen   = lenReg;

  // a fifth record length is never taken
  assert_rec_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadRec |-> recCnt < REC_W'(NUM_RECS));

  // no byte is accepted past the end of the file
  assert_in_file_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |-> CW'(cnt) < CW'(fileLen));

  // one file never reports both outcomes
  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(foundReg && missReg));

  // a match is only declared on a search-region byte
  assert_hit_in_scan_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.markHit |-> stb.scanByte);

endmodule

// File: rtl/bshp_ctrl.sv
module bshp_ctrl
  import bshp_pkg::*;
#(
  parameter bit RAW_MODE = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  dpStatusT stat,
  input  logic     inValid,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output strobeT   stb
);

  localparam phaseT FIRST_PHASE = RAW_MODE ? ST_HDR : ST_SCAN;

  phaseT phase, phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= FIRST_PHASE;
    else       phase <= phaseNext;
  end

  always_comb begin
    stb       = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    phaseNext = phase;
    case (phase)
      ST_HDR: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.take = 1'b1;
          if (stat.lastByte) begin
            stb.markMiss = 1'b1;
            stb.clrFile  = 1'b1;
            phaseNext    = FIRST_PHASE;
          end else begin
            stb.loadRec = stat.atRec;
            if (stat.scanNext) phaseNext = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.take     = 1'b1;
          stb.scanByte = 1'b1;
          if (stat.hit) begin
            stb.markHit = 1'b1;
            if (RAW_MODE) begin
              phaseNext = ST_EMIT;
            end else if (stat.lastByte) begin
              stb.clrFile = 1'b1;
              phaseNext   = FIRST_PHASE;
            end else begin
              phaseNext = ST_PASS;
            end
          end else if (stat.lastByte) begin
            stb.markMiss = 1'b1;
            stb.clrFile  = 1'b1;
            phaseNext    = FIRST_PHASE;
          end
        end
      end
      ST_EMIT: begin
        outValid     = 1'b1;
        stb.emitting = 1'b1;
        if (outReady) begin
          stb.emitStep = 1'b1;
          if (stat.emitLast) begin
            if (stat.tailEnd) begin
              stb.clrFile = 1'b1;
              phaseNext   = FIRST_PHASE;
            end else begin
              phaseNext = ST_PASS;
            end
          end
        end
      end
      default: begin
        inReady  = outReady;
        outValid = inValid;
        if (inValid && outReady) begin
          stb.take = 1'b1;
          if (stat.lastByte) begin
            stb.clrFile = 1'b1;
            phaseNext   = FIRST_PHASE;
          end
        end
      end
    endcase
  end

  // nothing leaves the block while the header is walked
  assert_hdr_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_HDR) |-> !outValid);

  // input is held off while the preamble is replayed
  assert_emit_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_EMIT) |-> !inReady);

endmodule

// File: rtl/bitstream_hdr_parser.sv
module bitstream_hdr_parser
  import bshp_pkg::*;
#(
  parameter bit RAW_MODE  = 1'b1,
  parameter int LEN_W     = 16,
  parameter int HDR_START = 15,
  parameter int NUM_RECS  = 4,
  parameter int PRE_RUN   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] fileLen,
  input  logic             inValid,
  input  logic [7:0]       inData,
  output logic             inReady,
  output logic             outValid,
  output logic [7:0]       outData,
  input  logic             outReady,
  output logic             payloadFound,
  output logic             notFound,
  output logic [LEN_W-1:0] payloadStart,
  output logic [LEN_W-1:0] payloadLen
);

  strobeT   stb;
  dpStatusT stat;

  bshp_ctrl #(
    .RAW_MODE(RAW_MODE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stat    (stat),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .stb     (stb)
  );

  bshp_datapath #(
    .RAW_MODE (RAW_MODE),
    .LEN_W    (LEN_W),
    .HDR_START(HDR_START),
    .NUM_RECS (NUM_RECS),
    .PRE_RUN  (PRE_RUN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .inData      (inData),
    .fileLen     (fileLen),
    .stat        (stat),
    .outData     (outData),
    .payloadFound(payloadFound),
    .notFound    (notFound),
    .payloadStart(payloadStart),
    .payloadLen  (payloadLen)
  );

endmodule

// File: tb/bitstream_hdr_parser_tb.sv
module bitstream_hdr_parser_tb;

  localparam int LW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rstN;

  logic          rValid, rReady, rOutValid, rOutReady, rFound, rMiss;
  logic [7:0]    rData, rOutData;
  logic [LW-1:0] rLen, rStart, rPLen;
  logic          cValid, cReady, cOutValid, cOutReady, cFound, cMiss;
  logic [7:0]    cData, cOutData;
  logic [LW-1:0] cLen, cStart, cPLen;

  bitstream_hdr_parser #(.RAW_MODE(1'b1), .LEN_W(LW)) u_dut (
    .clk(clk), .rstN(rstN), .fileLen(rLen), .inValid(rValid), .inData(rData),
    .inReady(rReady), .outValid(rOutValid), .outData(rOutData), .outReady(rOutReady),
    .payloadFound(rFound), .notFound(rMiss), .payloadStart(rStart), .payloadLen(rPLen));

  bitstream_hdr_parser #(.RAW_MODE(1'b0), .LEN_W(LW)) u_dutCmp (
    .clk(clk), .rstN(rstN), .fileLen(cLen), .inValid(cValid), .inData(cData),
    .inReady(cReady), .outValid(cOutValid), .outData(cOutData), .outReady(cOutReady),
    .payloadFound(cFound), .notFound(cMiss), .payloadStart(cStart), .payloadLen(cPLen));

  logic [7:0] fb   [0:255];
  logic [7:0] rOut [0:255];
  logic [7:0] cOut [0:255];
  int flen, rOutCnt, cOutCnt;
  int checks = 0, errors = 0;
  bit bpOn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // downstream ready pattern, changed away from the clock edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rOutReady = bpOn ? lfsr[0] : 1'b1;
    cOutReady = bpOn ? lfsr[3] : 1'b1;
  end

  // output collectors: a transfer happens at the next rising edge
  always @(negedge clk) begin
    if (rstN && rOutValid && rOutReady) begin
      if (rOutCnt < 256) rOut[rOutCnt] = rOutData;
      rOutCnt++;
    end
    if (rstN && cOutValid && cOutReady) begin
      if (cOutCnt < 256) cOut[cOutCnt] = cOutData;
      cOutCnt++;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    fb[flen] = b;
    flen++;
  endtask

  // uncompressed image: prelude, four records with 0xFF text, gap, run, payload
  task automatic buildRaw(input int l0, input int gap, input bit decoy,
                          input int ffRun, input int payN);
    flen = 0;
    for (int i = 0; i < 15; i++) put((i >= 3 && i <= 6) ? 8'hFF : 8'(i + 16));
    for (int k = 0; k < 4; k++) begin
      int l;
      l = (k == 0) ? l0 : k + 1;
      put(8'(l));
      for (int t = 0; t < l + 2; t++) put(8'hFF);
    end
    if (decoy) begin
      put(8'hFF); put(8'hFF); put(8'hFF); put(8'h00);
    end
    for (int i = 0; i < gap; i++) put(8'h5A);
    for (int i = 0; i < ffRun; i++) put(8'hFF);
    for (int i = 0; i < payN; i++) put(8'((i * 37 + 11) & 8'h7F));
  endtask

  task automatic buildCmp(input int n, input int p);
    flen = 0;
    for (int i = 0; i < n; i++) put(8'((i * 29 + 7) & 8'h7F));
    if (p >= 0) begin
      fb[p]     = 8'hFF;
      fb[p + 1] = 8'h30 | 8'(p & 15);
    end
  endtask

  // expected outcome worked out from the file layout
  function automatic void refParse(input bit raw, output bit f, output int st);
    int pos;
    f  = 1'b0;
    st = 0;
    if (raw) begin
      pos = 15;
      for (int k = 0; k < 4; k++) begin
        if (pos >= flen) return;
        pos += int'(fb[pos]) + 3;
      end
      for (int i = pos; i + 3 < flen; i++)
        if (fb[i] == 8'hFF && fb[i+1] == 8'hFF && fb[i+2] == 8'hFF && fb[i+3] == 8'hFF) begin
          f = 1'b1; st = i; return;
        end
    end else begin
      for (int i = 0; i < flen - 1; i++)
        if (fb[i] == 8'hFF && fb[i+1][7:4] == 4'h3) begin
          f = 1'b1; st = i + 2; return;
        end
    end
  endfunction

  task automatic sendByte(input bit raw, input logic [7:0] b);
    bit acc;
    acc = 1'b0;
    while (!acc) begin
      @(posedge clk); #2;
      if (raw) begin rValid = 1'b1; rData = b; end
      else     begin cValid = 1'b1; cData = b; end
      @(negedge clk);
      acc = raw ? rReady : cReady;
    end
  endtask

  task automatic runFile(input bit raw, input string tag);
    bit ef;
    int es, mism, oc;
    refParse(raw, ef, es);
    if (raw) begin rLen = LW'(flen); rOutCnt = 0; end
    else     begin cLen = LW'(flen); cOutCnt = 0; end
    for (int i = 0; i < flen; i++) sendByte(raw, fb[i]);
    @(posedge clk); #2;
    rValid = 1'b0;
    cValid = 1'b0;
    repeat (30) @(negedge clk);
    chk(tag, "found flag", raw ? int'(rFound) : int'(cFound), int'(ef));
    chk("R7", "not-found flag", raw ? int'(rMiss) : int'(cMiss), int'(!ef));
    if (ef) begin
      chk("R6", "payload start", raw ? int'(rStart) : int'(cStart), es);
      chk("R6", "payload length", raw ? int'(rPLen) : int'(cPLen), flen - es);
    end
    oc = raw ? rOutCnt : cOutCnt;
    chk("R4", "output byte count", oc, ef ? flen - es : 0);
    mism = 0;
    if (ef)
      for (int i = 0; i < oc && i < 256 && es + i < flen; i++)
        if ((raw ? rOut[i] : cOut[i]) != fb[es + i]) mism++;
    chk("R9", "payload byte mismatches", mism, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0;
    rValid = 1'b0; cValid = 1'b0; rData = '0; cData = '0;
    rLen = '0; cLen = '0; rOutCnt = 0; cOutCnt = 0;
    rOutReady = 1'b1; cOutReady = 1'b1;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk("R1", "raw inReady", int'(rReady), 1);
    chk("R1", "raw outValid", int'(rOutValid), 0);
    chk("R1", "raw flags", int'(rFound) + int'(rMiss), 0);
    chk("R1", "cmp inReady", int'(cReady), 1);
    chk("R1", "cmp outValid", int'(cOutValid), 0);
    chk("R1", "cmp flags", int'(cFound) + int'(cMiss), 0);

    // uncompressed sweep over record length, gap, decoys and run length
    for (int l0 = 0; l0 < 6; l0++)
      for (int gap = 0; gap < 4; gap++)
        for (int dc = 0; dc < 2; dc++)
          for (int run = 4; run < 6; run++) begin
            bpOn = ((l0 + gap + dc) % 2) == 1;
            buildRaw(l0, gap, dc[0], run, 6);
            runFile(1'b1, (gap == 0) ? "R2" : ((dc == 1 || run == 5) ? "R10" : "R3"));
          end
    bpOn = 1'b1;
    buildRaw(3, 1, 1'b0, 4, 0);   // preamble is the last four bytes
    runFile(1'b1, "R3");
    buildRaw(2, 2, 1'b1, 3, 5);   // only a three-byte run
    runFile(1'b1, "R7");
    buildRaw(5, 0, 1'b0, 4, 4);
    flen = 25;                    // ends inside the record walk
    runFile(1'b1, "R7");
    buildRaw(1, 1, 1'b0, 4, 3);   // straight after a failed file
    runFile(1'b1, "R8");

    // compressed sweep of the marker position
    for (int p = 0; p < 11; p++) begin
      bpOn = (p % 2) == 1;
      buildCmp(12, p);
      runFile(1'b0, "R5");
    end
    bpOn = 1'b1;
    buildCmp(12, -1);
    fb[3] = 8'hFF; fb[4] = 8'hFF; fb[5] = 8'h35;
    runFile(1'b0, "R10");
    buildCmp(12, -1);
    runFile(1'b0, "R7");
    buildCmp(12, -1);
    fb[2] = 8'hFF; fb[3] = 8'h2C; fb[11] = 8'hFF;
    runFile(1'b0, "R7");
    buildCmp(14, 6);
    runFile(1'b0, "R8");

    summary();
    $finish;
  end

endmodule